// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox Controller

This block lets two processors signal each other over up to sixteen doorbell channels in each direction. Each processor owns a small register bank. From its bank a processor raises an occupied flag on a channel to tell its peer that something is waiting. It clears the flags its peer has raised toward it to acknowledge them. It also masks receive and transmit interrupts one channel at a time. No message data passes through the block. Data sits in shared memory elsewhere, and the block only carries the "something is waiting" and "slot is free again" events.

One set/clear register in each bank does two jobs. Bits written in its upper half raise the caller's own outgoing flags. Bits written in its lower half clear the peer's flags aimed at the caller. Each processor has a receive interrupt, which fires on unmasked peer flags that are set. It also has a transmit interrupt, which fires on unmasked own flags that are clear. Both interrupt outputs are level outputs.

Access is through a simple synchronous register bus. The bus has read and write strobes, a byte address, 32-bit write data and a processor-select bit that identifies the requester. Read data appears one clock after the read strobe.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, all occupied flags and both enable bits are 0 in both banks, and all mask bits are 1. Both irq_rx and irq_tx are 0 and rd_data is 0.
- R2: Processor 0's bank occupies byte offsets 0x00-0x0C and processor 1's bank occupies 0x10-0x1C. Within a bank, +0x0 is control, +0x4 is mask, +0x8 is set/clear and +0xC is status. rd_data shows the addressed register on the clock after the rd_en cycle and holds until the next read.
- R3: Control bit 0 is the receive enable and control bit 16 is the transmit enable. Both read back as written, and every other control bit reads 0.
- R4: In the mask register, bit n masks channel n's receive interrupt and bit 16+n masks its transmit interrupt (1 = masked). The register reads back as written.
- R5: Writing 1 to set/clear bit 16+n raises the writing processor's occupied flag for channel n. Zero bits change nothing.
- R6: Writing 1 to set/clear bit n clears the peer's occupied flag for channel n. Zero bits change nothing.
- R7: Status bits [NUM_CH-1:0] show the bank owner's own occupied flags and the upper bits read 0. The set/clear register always reads 0.
- R8: irq_rx[p] is 1 exactly when processor p's receive enable is set and some channel n has the peer's flag set while p's receive mask bit n is 0.
- R9: irq_tx[p] is 1 exactly when processor p's transmit enable is set and some channel n has p's own flag clear while p's transmit mask bit n is 0.
- R10: Address 0x3F0 reads NUM_CH in bits [7:0]. Address 0x3F4 reads VER_MAJOR in bits [7:4] and VER_MINOR in bits [3:0]. Writes to these two addresses and to status registers change nothing.
- R11: A write whose bus_proc differs from the addressed bank (bank = address bit 4) is ignored. Reads of either bank are allowed from either processor.
- R12: Reads of any address not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_proc | input | 1 | Requesting processor (0 or 1) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after bus_rd |
| irq_rx | output | 2 | Per-processor receive (channel occupied) interrupt |
| irq_tx | output | 2 | Per-processor transmit (channel free) interrupt |

## Verification
The bench checks that a write to one half of the set/clear register touches the other processor's flags only through the lower half. A design that crossed the halves would leave the acknowledged channel occupied, or would flip the wrong side's flag. It checks the opposite polarities of the two interrupts. A swapped polarity would fire transmit while a channel is busy, or receive when nothing is pending. It also checks that writes are rejected when the processor select does not match the addressed bank, and that writes to read-only locations are dropped. A design that let these through would corrupt the peer's state. A behavioural model compares both interrupt outputs on every clock and runs through a pseudo-random mix of accesses from both processors, including foreign writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NPROC      = 2;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned HALF       = 16;
  localparam int unsigned HWCFG_ADDR = 'h3F0;
  localparam int unsigned VER_ADDR   = 'h3F4;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STATUS = 2'd3
  } bank_reg_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                     bus_wr,
  input  logic                     bus_proc,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [NPROC-1:0]         wr_ctrl,
  output logic [NPROC-1:0]         wr_mask,
  output logic [NPROC-1:0][NUM_CH-1:0] set_req,
  output logic [NPROC-1:0][NUM_CH-1:0] clr_req,
  output logic                     rd_in_bank,
  output logic                     rd_bank,
  output bank_reg_e                rd_reg,
  output logic                     rd_hwcfg,
  output logic                     rd_ver
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              in_bank;
  logic              bank;
  bank_reg_e         regsel;
  logic              wr_ok;
  logic [NPROC-1:0]  wr_sc;
  logic [1:0]        unused_lsb;

  assign unused_lsb = bus_addr[1:0];
  assign word    = bus_addr[ADDR_W-1:2];
  assign in_bank = (bus_addr[ADDR_W-1:5] == '0);
  assign bank    = bus_addr[4];
  assign regsel  = bank_reg_e'(bus_addr[3:2]);
  assign wr_ok   = bus_wr & in_bank & (bus_proc == bank);

  genvar b;
  generate
    for (b = 0; b < NPROC; b++) begin : g_bank
      assign wr_ctrl[b] = wr_ok & (bank == b[0]) & (regsel == REG_CTRL);
      assign wr_mask[b] = wr_ok & (bank == b[0]) & (regsel == REG_MASK);
      assign wr_sc[b]   = wr_ok & (bank == b[0]) & (regsel == REG_SETCLR);
    end
    for (b = 0; b < NPROC; b++) begin : g_req
      assign set_req[b] = wr_sc[b]       ? bus_wdata[HALF +: NUM_CH] : '0;
      assign clr_req[b] = wr_sc[NPROC-1-b] ? bus_wdata[NUM_CH-1:0]  : '0;
    end
  endgenerate

  assign rd_in_bank = in_bank;
  assign rd_bank    = bank;
  assign rd_reg     = regsel;
  assign rd_hwcfg   = (word == WORD_W'(HWCFG_ADDR >> 2));
  assign rd_ver     = (word == WORD_W'(VER_ADDR >> 2));
endmodule

// File: rtl/mbx_bank_regs.sv
module mbx_bank_regs
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic              rx_en,
  output logic              tx_en,
  output logic [NUM_CH-1:0] mask_rx,
  output logic [NUM_CH-1:0] mask_tx
);
  logic              rx_en_d, tx_en_d;
  logic [NUM_CH-1:0] mask_rx_d, mask_tx_d;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_wdata = wdata;

  always_comb begin
    rx_en_d   = rx_en;
    tx_en_d   = tx_en;
    mask_rx_d = mask_rx;
    mask_tx_d = mask_tx;
    if (wr_ctrl) begin
      rx_en_d = wdata[0];
      tx_en_d = wdata[HALF];
    end
    if (wr_mask) begin
      mask_rx_d = wdata[NUM_CH-1:0];
      mask_tx_d = wdata[HALF +: NUM_CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (wr_ctrl) begin
      rx_en <= rx_en_d;
      tx_en <= tx_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_rx <= '1;
      mask_tx <= '1;
    end else if (wr_mask) begin
      mask_rx <= mask_rx_d;
      mask_tx <= mask_tx_d;
    end
  end

  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> ($stable(mask_rx) && $stable(mask_tx)));
  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (rx_en == $past(wdata[0]) && tx_en == $past(wdata[HALF])));
endmodule

// File: rtl/mbx_occ_flags.sv
module mbx_occ_flags
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPROC-1:0][NUM_CH-1:0] set_req,
  input  logic [NPROC-1:0][NUM_CH-1:0] clr_req,
  output logic [NPROC-1:0][NUM_CH-1:0] occ
);
  logic [NPROC-1:0][NUM_CH-1:0] occ_d;
  logic [NPROC-1:0]             upd;

  genvar p;
  generate
    for (p = 0; p < NPROC; p++) begin : g_proc
      always_comb begin
        occ_d[p] = (occ[p] | set_req[p]) & ~clr_req[p];
        upd[p]   = (|set_req[p]) | (|clr_req[p]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      occ[p] <= '0;
        else if (upd[p]) occ[p] <= occ_d[p];
      end

      assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_req[p]) |=> ((occ[p] & $past(set_req[p] & ~clr_req[p])) == $past(set_req[p] & ~clr_req[p])));
      assert_clr_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_req[p]) |=> ((occ[p] & $past(clr_req[p])) == '0));
      assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|set_req[p] || |clr_req[p]) |=> $stable(occ[p]));
    end
  endgenerate
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [NUM_CH-1:0] mask_rx,
  input  logic [NUM_CH-1:0] mask_tx,
  input  logic [NUM_CH-1:0] own_occ,
  input  logic [NUM_CH-1:0] peer_occ,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [NUM_CH-1:0] rx_pend, tx_free;

  always_comb begin
    rx_pend = peer_occ & ~mask_rx;
    tx_free = ~own_occ & ~mask_tx;
    irq_rx  = rx_en & (|rx_pend);
    irq_tx  = tx_en & (|tx_free);
  end
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned ADDR_W    = 10,
  parameter logic [3:0]  VER_MAJOR = 4'd1,
  parameter logic [3:0]  VER_MINOR = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_proc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic [1:0]        irq_rx,
  output logic [1:0]        irq_tx
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [NPROC-1:0]             wr_ctrl, wr_mask;
  logic [NPROC-1:0][NUM_CH-1:0] set_req, clr_req, occ;
  logic [NPROC-1:0]             rx_en, tx_en;
  logic [NPROC-1:0][NUM_CH-1:0] mask_rx, mask_tx;
  logic                         rd_in_bank, rd_bank, rd_hwcfg, rd_ver;
  bank_reg_e                    rd_reg;

  mbx_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_proc(bus_proc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_ctrl(wr_ctrl), .wr_mask(wr_mask), .set_req(set_req), .clr_req(clr_req),
    .rd_in_bank(rd_in_bank), .rd_bank(rd_bank), .rd_reg(rd_reg),
    .rd_hwcfg(rd_hwcfg), .rd_ver(rd_ver)
  );

  mbx_occ_flags #(.NUM_CH(NUM_CH)) u_occ (
    .clk(clk), .rst_n(rst_n_s), .set_req(set_req), .clr_req(clr_req), .occ(occ)
  );

  genvar p;
  generate
    for (p = 0; p < NPROC; p++) begin : g_proc
      mbx_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n_s), .wr_ctrl(wr_ctrl[p]), .wr_mask(wr_mask[p]),
        .wdata(bus_wdata), .rx_en(rx_en[p]), .tx_en(tx_en[p]),
        .mask_rx(mask_rx[p]), .mask_tx(mask_tx[p])
      );
      mbx_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
        .rx_en(rx_en[p]), .tx_en(tx_en[p]), .mask_rx(mask_rx[p]), .mask_tx(mask_tx[p]),
        .own_occ(occ[p]), .peer_occ(occ[NPROC-1-p]),
        .irq_rx(irq_rx[p]), .irq_tx(irq_tx[p])
      );
    end
  endgenerate

  logic [31:0] rd_val, rd_data_d;

  always_comb begin
    rd_val = '0;
    if (rd_in_bank) begin
      unique case (rd_reg)
        REG_CTRL: begin
          rd_val[0]    = rx_en[rd_bank];
          rd_val[HALF] = tx_en[rd_bank];
        end
        REG_MASK: begin
          rd_val[NUM_CH-1:0]    = mask_rx[rd_bank];
          rd_val[HALF +: NUM_CH] = mask_tx[rd_bank];
        end
        REG_SETCLR: rd_val = '0;
        REG_STATUS: rd_val[NUM_CH-1:0] = occ[rd_bank];
        default:    rd_val = '0;
      endcase
    end else if (rd_hwcfg) begin
      rd_val[7:0] = 8'(NUM_CH);
    end else if (rd_ver) begin
      rd_val[7:0] = {VER_MAJOR, VER_MINOR};
    end
  end

  always_comb begin
    rd_data_d = rd_data;
    if (bus_rd) rd_data_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rd_data <= '0;
    else if (bus_rd) rd_data <= rd_data_d;
  end

  assert_setclr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_rd && bus_addr[ADDR_W-1:5] == '0 && bus_addr[3:2] == 2'd2) |=> (rd_data == '0));
  assert_foreign_write_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr[ADDR_W-1:5] == '0 && bus_addr[4] != bus_proc) |=>
      ($stable(occ) && $stable(mask_rx) && $stable(mask_tx) && $stable(rx_en) && $stable(tx_en)));
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !bus_rd |=> $stable(rd_data));
endmodule

// File: tb/mbx_doorbell_top_test.sv
module mbx_doorbell_top_test;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              bus_rd = 1'b0, bus_wr = 1'b0, bus_proc = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       rd_data;
  logic [1:0]        irq_rx, irq_tx;

  mbx_doorbell_top #(.NUM_CH(16), .ADDR_W(ADDR_W), .VER_MAJOR(4'd1), .VER_MINOR(4'd0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_proc(bus_proc),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit cmp_en  = 1'b0;
  bit done    = 1'b0;

  logic [15:0] m_occ [2];
  logic [15:0] m_mrx [2];
  logic [15:0] m_mtx [2];
  bit          m_rxe [2];
  bit          m_txe [2];

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_occ[i] = '0; m_mrx[i] = '1; m_mtx[i] = '1; m_rxe[i] = 0; m_txe[i] = 0;
    end
  endtask

  task automatic model_write(input int p, input int a, input logic [31:0] d);
    int b, r;
    if (a >= 32) return;
    b = (a >> 4) & 1;
    r = (a >> 2) & 3;
    if (b != p) return;
    case (r)
      0: begin m_rxe[b] = d[0]; m_txe[b] = d[16]; end
      1: begin m_mrx[b] = d[15:0]; m_mtx[b] = d[31:16]; end
      2: begin m_occ[b] = m_occ[b] | d[31:16]; m_occ[1-b] = m_occ[1-b] & ~d[15:0]; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input int a);
    int b, r;
    if (a == 'h3F0) return 32'd16;
    if (a == 'h3F4) return 32'h10;
    if (a >= 32) return 32'd0;
    b = (a >> 4) & 1;
    r = (a >> 2) & 3;
    case (r)
      0: return {15'd0, m_txe[b], 15'd0, m_rxe[b]};
      1: return {m_mtx[b], m_mrx[b]};
      3: return {16'd0, m_occ[b]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [1:0] exp_rx();
    logic [1:0] v;
    for (int p = 0; p < 2; p++) v[p] = m_rxe[p] && |(m_occ[1-p] & ~m_mrx[p]);
    return v;
  endfunction

  function automatic logic [1:0] exp_tx();
    logic [1:0] v;
    for (int p = 0; p < 2; p++) v[p] = m_txe[p] && |(~m_occ[p] & ~m_mtx[p]);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R8 irq_rx per-clock", {30'd0, irq_rx}, {30'd0, exp_rx()});
      chk("R9 irq_tx per-clock", {30'd0, irq_tx}, {30'd0, exp_tx()});
    end
  end

  task automatic do_wr(input int p, input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_proc = p[0]; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(posedge clk);
    model_write(p, a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int p, input int a, input string tag);
    logic [31:0] exp;
    exp = model_read(a);
    bus_rd = 1'b1; bus_proc = p[0]; bus_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lf;
    model_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: reset values in both banks
    chk("R1 rd_data after reset", rd_data, 32'd0);
    chk("R1 irq after reset", {28'd0, irq_rx, irq_tx}, 32'd0);
    do_rd(0, 'h00, "R1 ctrl bank0");
    do_rd(0, 'h04, "R1 R4 mask bank0 all ones");
    do_rd(1, 'h14, "R1 R2 mask bank1 all ones");
    do_rd(1, 'h1C, "R1 R2 status bank1");

    // R10: identification registers, read-only
    do_rd(0, 'h3F0, "R10 hwcfg");
    do_rd(1, 'h3F4, "R10 version");
    do_wr(0, 'h3F0, 32'hFFFF_FFFF);
    do_rd(0, 'h3F0, "R10 hwcfg after write");
    do_wr(0, 'h0C, 32'hFFFF_FFFF);
    do_rd(0, 'h0C, "R10 status write ignored");

    // R3: control enables, other bits ignored
    do_wr(0, 'h00, 32'hFFFF_FFFF);
    do_rd(1, 'h00, "R3 ctrl bank0 readback");
    do_wr(1, 'h10, 32'h0001_0001);
    do_rd(1, 'h10, "R3 ctrl bank1 readback");

    // R4 / R9: unmask tx ch3 on proc0 -> channel free interrupt
    do_wr(0, 'h04, 32'hFFF7_FFFF);
    do_rd(0, 'h04, "R4 mask bank0 readback");
    chk("R9 tx free irq", {31'd0, irq_tx[0]}, 32'd1);
    do_wr(1, 'h14, 32'hFFFF_FFF7);

    // R5 / R8 / R9: proc0 raises ch3
    do_wr(0, 'h08, 32'h0008_0000);
    do_rd(0, 'h0C, "R5 R7 status bank0 ch3");
    do_rd(0, 'h08, "R7 setclr reads zero");
    chk("R8 rx irq proc1", {31'd0, irq_rx[1]}, 32'd1);
    chk("R9 tx irq drops when busy", {31'd0, irq_tx[0]}, 32'd0);

    // R11: foreign write ignored
    do_wr(1, 'h08, 32'h0020_0000);
    do_rd(0, 'h0C, "R11 foreign setclr ignored");
    do_wr(1, 'h04, 32'h0000_0000);
    do_rd(0, 'h04, "R11 foreign mask ignored");

    // R5: zero bits do nothing
    do_wr(0, 'h08, 32'h0000_0000);
    do_rd(0, 'h0C, "R5 zero write no effect");

    // R6: proc1 acknowledges ch3
    do_wr(1, 'h18, 32'h0000_0008);
    do_rd(1, 'h0C, "R6 ack clears peer flag");
    chk("R6 R8 rx irq cleared", {31'd0, irq_rx[1]}, 32'd0);

    // R8: masked receive stays quiet until unmasked
    do_wr(0, 'h00, 32'h0000_0001);
    do_wr(1, 'h18, 32'h0080_0000);
    chk("R8 masked rx quiet", {31'd0, irq_rx[0]}, 32'd0);
    do_wr(0, 'h04, 32'hFFFF_FF7F);
    chk("R8 unmasked rx fires", {31'd0, irq_rx[0]}, 32'd1);

    // R12: undecoded
    do_rd(0, 'h100, "R12 undecoded reads zero");
    do_rd(1, 'h3F8, "R12 undecoded high reads zero");

    // mixed traffic from both processors
    lf = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      int op, b, p;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op = lf[2:0];
      b  = lf[3];
      p  = (lf[7:4] == 4'd0) ? 1 - b : b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (op)
        0: do_wr(p, b * 16 + 0, lf);
        1: do_wr(p, b * 16 + 4, lf);
        2, 3, 4: do_wr(p, b * 16 + 8, lf);
        default: do_rd(p, b * 16 + (lf[1:0] * 4), "R2 R7 mixed read");
      endcase
    end
    do_rd(0, 'h0C, "R5 R6 final status bank0");
    do_rd(1, 'h1C, "R5 R6 final status bank1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule